// File: doc/BRIEF.md
# Operand Register File with Tagged Result Bypass

This block supplies the two source operands of a pipelined RISC core's decode stage. Its storage is a 32-entry by 32-bit register file with two synchronous read ports and one write port. Each cycle it reads both source fields of the fetched instruction word. It does this without decoding whether the instruction uses them, so the data is ready when that word enters decode. A register whose write lands on the same edge as the read would come back stale from the storage. A two-entry buffer of recent single-cycle ALU results, each tagged with its destination, overrides the storage output for such registers.

Loads and multi-cycle operations are not put into the buffer. When such an operation is issued, the core marks its destination as pending. Any decode-stage instruction that names a pending register raises a stall. While stalled, the block holds the decode word, ignores the fetched word and re-reads the same registers on every edge. When the late result is written back, the stall drops in that same cycle and the written value goes straight to the waiting operand. An instruction whose storage read happened on the write-back edge is held for one extra cycle, so that its re-read returns the new value.

Top module: `operand_regfile`

## Requirements
- R1: Reset (rst_ni low) clears the decode word to zero and forgets every pending register. After reset, stall_o is low and both operands read 0. A register marked pending before reset does not stall a reader afterwards.
- R2: opa_o returns the register named by bits 31..27 of the decode word, and opb_o returns the one named by bits 26..22. A word presented on instr_i becomes the decode word one edge later, unless stall_o is high.
- R3: In one clock, a write to one register and the reads of two other registers do not disturb each other.
- R4: A write with wr_fwd_i=1 that is committed on the edge that loads the decode word is visible on the operand outputs in the following decode cycle.
- R5: If two writes to the same register with wr_fwd_i=1 land on consecutive edges, a reader sees the later value.
- R6: Register 0 always reads as 0. A write to it, forwarded or not, has no effect.
- R7: pend_set_i with a nonzero pend_addr_i marks that register pending from the next edge on. While a decode source names a pending register, stall_o is high, dec_instr_o holds, and instr_i is ignored.
- R8: A write with wr_fwd_i=0 clears the pending mark of its register. In the cycle it is presented, stall_o drops for a reader of that register, and the operand equals wr_data_i.
- R9: A decode word whose source register received a wr_fwd_i=0 write on the edge that loaded the word sees stall_o high for exactly one cycle. After that cycle it reads the written value.
- R10: A wr_fwd_i=0 write replaces any older buffered value of the same register, so later reads return the newer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Fetched instruction word, taken into decode when not stalled |
| pend_set_i | input | 1 | A load or multi-cycle operation is issued |
| pend_addr_i | input | 5 | Destination register of that operation |
| wr_en_i | input | 1 | Register write strobe, committed on the next edge |
| wr_fwd_i | input | 1 | 1: single-cycle ALU result (buffered); 0: late result write-back |
| wr_addr_i | input | 5 | Write destination register |
| wr_data_i | input | 32 | Write data |
| dec_instr_o | output | 32 | Instruction word held in decode |
| opa_o | output | 32 | Operand for source field bits 31..27 |
| opb_o | output | 32 | Operand for source field bits 26..22 |
| stall_o | output | 1 | Decode stall request |

## Verification
The hardest case to reach from the ports is a stale read that the bypass buffer must cover. The instruction has to be fetched in exactly the cycle whose edge commits the write it depends on. Two such writes to one register must also fall on consecutive edges, so that both buffer entries carry the same tag. The stimulus table schedules fetch words and writes cycle by cycle to line these up. It uses the same alignment for the one-cycle hold after a late write-back, and for the case where a buffered ALU value must be dropped because a later write-back to its register has replaced it. A behavioural model in the bench, built only from the requirements, gives the expected operands and stall for every row.

// File: rtl/orf_pkg.sv
package orf_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned NUM_REGS  = 32;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned FWD_DEPTH = 2;
  localparam int unsigned NUM_RD    = 2;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_WB,
    SRC_FWD,
    SRC_RAM
  } opnd_src_e;
endpackage

// File: rtl/orf_ram.sv
module orf_ram #(
  parameter  int unsigned NREG = orf_pkg::NUM_REGS,
  parameter  int unsigned DW   = orf_pkg::XLEN,
  parameter  int unsigned NRD  = orf_pkg::NUM_RD,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i != '0) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write: same-edge write is not visible on rdata
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk_i) q <= mem_q[raddr_i[p]];
    assign rdata_o[p] = q;
  end
endmodule

// File: rtl/orf_fwd_buf.sv
module orf_fwd_buf #(
  parameter int unsigned DEPTH = orf_pkg::FWD_DEPTH,
  parameter int unsigned DW    = orf_pkg::XLEN,
  parameter int unsigned AW    = 5,
  parameter int unsigned NRD   = orf_pkg::NUM_RD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          kill_i,
  input  logic [AW-1:0] kill_addr_i,
  input  logic [AW-1:0] look_addr_i [NRD],
  output logic          hit_o       [NRD],
  output logic [DW-1:0] look_data_o [NRD]
);
  // entry 0 is the newest
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (push_i) begin
      vld_q[0] <= 1'b1;
      tag_q[0] <= push_addr_i;
      dat_q[0] <= push_data_i;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i] <= vld_q[i-1];
        tag_q[i] <= tag_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end else if (kill_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tag_q[i] == kill_addr_i) vld_q[i] <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_look
    logic          hit;
    logic [DW-1:0] dat;
    always_comb begin
      hit = 1'b0;
      dat = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (vld_q[i] && tag_q[i] == look_addr_i[p]) begin
          hit = 1'b1;
          dat = dat_q[i];
        end
      end
    end
    assign hit_o[p]       = hit;
    assign look_data_o[p] = dat;
  end
endmodule

// File: rtl/orf_scoreboard.sv
module orf_scoreboard #(
  parameter  int unsigned NREG = orf_pkg::NUM_REGS,
  parameter  int unsigned NRD  = orf_pkg::NUM_RD,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_i,
  input  logic [AW-1:0] clr_addr_i,
  input  logic [AW-1:0] src_addr_i [NRD],
  output logic          stall_o
);
  logic [NREG-1:0] pend_q;
  logic            last_vld_q;
  logic [AW-1:0]   last_addr_q;
  logic [NRD-1:0]  busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      last_vld_q  <= 1'b0;
      last_addr_q <= '0;
    end else begin
      for (int r = 1; r < NREG; r++) begin
        if (set_i && set_addr_i == AW'(r))      pend_q[r] <= 1'b1;
        else if (clr_i && clr_addr_i == AW'(r)) pend_q[r] <= 1'b0;
      end
      last_vld_q  <= clr_i;
      last_addr_q <= clr_addr_i;
    end
  end

  // pending and not being written now, or written on the edge of the last read
  for (genvar p = 0; p < NRD; p++) begin : g_busy
    assign busy[p] = (src_addr_i[p] != '0) &&
                     ((pend_q[src_addr_i[p]] && !(clr_i && clr_addr_i == src_addr_i[p])) ||
                      (last_vld_q && last_addr_q == src_addr_i[p]));
  end

  assign stall_o = |busy;
endmodule

// File: rtl/operand_regfile.sv
module operand_regfile #(
  parameter  int unsigned NREG      = orf_pkg::NUM_REGS,
  parameter  int unsigned XLEN      = orf_pkg::XLEN,
  parameter  int unsigned IW        = orf_pkg::INSN_W,
  parameter  int unsigned FWD_DEPTH = orf_pkg::FWD_DEPTH,
  localparam int unsigned AW        = $clog2(NREG),
  localparam int unsigned NRD       = orf_pkg::NUM_RD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   instr_i,
  input  logic            pend_set_i,
  input  logic [AW-1:0]   pend_addr_i,
  input  logic            wr_en_i,
  input  logic            wr_fwd_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [IW-1:0]   dec_instr_o,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o,
  output logic            stall_o
);
  import orf_pkg::*;

  logic [IW-1:0]   dec_q;
  logic [IW-1:0]   fetch_word;
  logic [AW-1:0]   raddr    [NRD];
  logic [AW-1:0]   src_addr [NRD];
  logic [XLEN-1:0] ram_q    [NRD];
  logic            fwd_hit  [NRD];
  logic [XLEN-1:0] fwd_dat  [NRD];
  logic [XLEN-1:0] opnd     [NRD];
  logic            wb_late;
  logic            fwd_push;
  logic            stall;

  assign wb_late  = wr_en_i && !wr_fwd_i;
  assign fwd_push = wr_en_i && wr_fwd_i && (wr_addr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dec_q <= '0;
    else if (!stall) dec_q <= instr_i;
  end

  // stalled: re-read the held word
  assign fetch_word = stall ? dec_q : instr_i;

  for (genvar p = 0; p < NRD; p++) begin : g_field
    localparam int unsigned LSB = IW - (p + 1) * AW;
    assign raddr[p]    = fetch_word[LSB +: AW];
    assign src_addr[p] = dec_q[LSB +: AW];
  end

  orf_ram #(.NREG(NREG), .DW(XLEN), .NRD(NRD)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (ram_q)
  );

  orf_fwd_buf #(.DEPTH(FWD_DEPTH), .DW(XLEN), .AW(AW), .NRD(NRD)) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (fwd_push),
    .push_addr_i (wr_addr_i),
    .push_data_i (wr_data_i),
    .kill_i      (wb_late),
    .kill_addr_i (wr_addr_i),
    .look_addr_i (src_addr),
    .hit_o       (fwd_hit),
    .look_data_o (fwd_dat)
  );

  orf_scoreboard #(.NREG(NREG), .NRD(NRD)) u_sb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (pend_set_i && pend_addr_i != '0),
    .set_addr_i (pend_addr_i),
    .clr_i      (wb_late && wr_addr_i != '0),
    .clr_addr_i (wr_addr_i),
    .src_addr_i (src_addr),
    .stall_o    (stall)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_opnd
    opnd_src_e       sel;
    logic [XLEN-1:0] val;
    always_comb begin
      if (src_addr[p] == '0)                        sel = SRC_ZERO;
      else if (wb_late && wr_addr_i == src_addr[p]) sel = SRC_WB;
      else if (fwd_hit[p])                          sel = SRC_FWD;
      else                                          sel = SRC_RAM;
    end
    always_comb begin
      unique case (sel)
        SRC_ZERO: val = '0;
        SRC_WB:   val = wr_data_i;
        SRC_FWD:  val = fwd_dat[p];
        default:  val = ram_q[p];
      endcase
    end
    assign opnd[p] = val;
  end

  assign dec_instr_o = dec_q;
  assign opa_o       = opnd[0];
  assign opb_o       = opnd[1];
  assign stall_o     = stall;
endmodule

// File: rtl/operand_regfile_chk.sv
module operand_regfile_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] dec_instr_o,
  input logic [DW-1:0] opa_o,
  input logic [DW-1:0] opb_o,
  input logic          stall_o,
  input logic          wr_en_i,
  input logic          wr_fwd_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i
);
  logic [AW-1:0] s1, s2;
  assign s1 = dec_instr_o[IW-1 -: AW];
  assign s2 = dec_instr_o[IW-AW-1 -: AW];

  p_zero_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1 == '0 |-> opa_o == '0) and (s2 == '0 |-> opb_o == '0));

  p_hold_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(dec_instr_o));

  p_wb_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_fwd_i && s1 != '0 && wr_addr_i == s1 && !stall_o) |-> opa_o == wr_data_i);

  p_alu_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && wr_fwd_i) && s1 != '0 && s1 == $past(wr_addr_i) &&
     !stall_o && !(wr_en_i && !wr_fwd_i && wr_addr_i == s1)) |-> opa_o == $past(wr_data_i));

  p_settle_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && !wr_fwd_i) && s1 != '0 && s1 == $past(wr_addr_i))
    |-> stall_o);
endmodule

bind operand_regfile operand_regfile_chk #(.AW(AW), .DW(XLEN), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_instr_o (dec_instr_o),
  .opa_o       (opa_o),
  .opb_o       (opb_o),
  .stall_o     (stall_o),
  .wr_en_i     (wr_en_i),
  .wr_fwd_i    (wr_fwd_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/operand_regfile_bench.sv
module operand_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        pend_set;
  logic [4:0]  pend_addr;
  logic        wr_en, wr_fwd;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] dec_instr, opa, opb;
  logic        stall;

  always #10 clk = ~clk;

  operand_regfile u_operand_regfile (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
    .pend_set_i(pend_set), .pend_addr_i(pend_addr),
    .wr_en_i(wr_en), .wr_fwd_i(wr_fwd), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dec_instr_o(dec_instr), .opa_o(opa), .opb_o(opb), .stall_o(stall)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // requirement-level model
  logic [31:0] m_rf [32];
  logic [31:0] m_pend;
  logic        m_last_vld;
  logic [4:0]  m_last;
  logic [31:0] m_dec;

  typedef struct packed {
    logic [4:0]  s1;
    logic [4:0]  s2;
    logic        we;
    logic        fwd;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        ps;
    logic [4:0]  pa;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{5'd0, 5'd0, 1'b1, 1'b1, 5'd1, 32'h1111_0001, 1'b0, 5'd0, 4'd2},
    '{5'd0, 5'd0, 1'b1, 1'b1, 5'd2, 32'h2222_0002, 1'b0, 5'd0, 4'd2},
    '{5'd1, 5'd2, 1'b1, 1'b1, 5'd3, 32'h3333_0003, 1'b0, 5'd0, 4'd3},
    '{5'd4, 5'd1, 1'b1, 1'b1, 5'd4, 32'h4444_0004, 1'b0, 5'd0, 4'd3},
    '{5'd3, 5'd2, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd4},
    '{5'd0, 5'd0, 1'b1, 1'b1, 5'd5, 32'h5555_000A, 1'b0, 5'd0, 4'd2},
    '{5'd5, 5'd0, 1'b1, 1'b1, 5'd5, 32'h5555_000B, 1'b0, 5'd0, 4'd5},
    '{5'd0, 5'd5, 1'b1, 1'b1, 5'd0, 32'hDEAD_BEEF, 1'b0, 5'd0, 4'd5},
    '{5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd6},
    '{5'd6, 5'd1, 1'b0, 1'b0, 5'd0, 32'h0,         1'b1, 5'd6, 4'd6},
    '{5'd1, 5'd1, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd7},
    '{5'd1, 5'd1, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd7},
    '{5'd2, 5'd2, 1'b1, 1'b0, 5'd6, 32'h6666_0006, 1'b0, 5'd0, 4'd8},
    '{5'd6, 5'd2, 1'b1, 1'b0, 5'd6, 32'h6666_0007, 1'b0, 5'd0, 4'd8},
    '{5'd1, 5'd1, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd9},
    '{5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd9},
    '{5'd0, 5'd0, 1'b1, 1'b1, 5'd7, 32'h7777_0071, 1'b0, 5'd0, 4'd10},
    '{5'd0, 5'd0, 1'b1, 1'b0, 5'd7, 32'h7777_0072, 1'b0, 5'd0, 4'd10},
    '{5'd7, 5'd7, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd10},
    '{5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0,         1'b0, 5'd0, 4'd10}
  };

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";   6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pend     = '0;
    m_last_vld = 1'b0;
    m_last     = '0;
    m_dec      = '0;
  endtask

  // one cycle: drive, sample before the edge, advance model after it
  task automatic step(input logic [4:0] s1, input logic [4:0] s2,
                      input logic we, input logic fwd, input logic [4:0] wa,
                      input logic [31:0] wd, input logic ps, input logic [4:0] pa,
                      input int tag);
    logic [4:0]  d1, d2;
    logic        late, b1, b2, st1, st2, exp_stall;
    logic [31:0] e1, e2;
    instr = {s1, s2, 22'h0};
    wr_en = we; wr_fwd = fwd; wr_addr = wa; wr_data = wd;
    pend_set = ps; pend_addr = pa;
    #8;
    d1   = m_dec[31:27];
    d2   = m_dec[26:22];
    late = we && !fwd && wa != 5'd0;
    b1   = d1 != 0 && m_pend[d1] && !(late && wa == d1);
    b2   = d2 != 0 && m_pend[d2] && !(late && wa == d2);
    st1  = d1 != 0 && m_last_vld && m_last == d1;
    st2  = d2 != 0 && m_last_vld && m_last == d2;
    exp_stall = b1 || b2 || st1 || st2;
    e1 = (d1 == 0) ? 32'h0 : (late && wa == d1) ? wd : m_rf[d1];
    e2 = (d2 == 0) ? 32'h0 : (late && wa == d2) ? wd : m_rf[d2];
    check(exp_stall ? ((st1 || st2) ? "R9" : "R7") : tname(tag), "stall",
          {31'h0, stall}, {31'h0, exp_stall});
    check("R2", "decode word", dec_instr, m_dec);
    if (!exp_stall) begin
      check((d1 == 0) ? "R6" : (late && wa == d1) ? "R8" : tname(tag), "opa", opa, e1);
      check((d2 == 0) ? "R6" : (late && wa == d2) ? "R8" : tname(tag), "opb", opb, e2);
    end
    @(posedge clk);
    #2;
    if (!exp_stall) m_dec = {s1, s2, 22'h0};
    if (we && wa != 0) m_rf[wa] = wd;
    m_last_vld = late;
    m_last     = wa;
    if (late) m_pend[wa] = 1'b0;
    if (ps && pa != 0) m_pend[pa] = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    model_reset();
    rst_n = 1'b0;
    instr = '0; pend_set = 1'b0; pend_addr = '0;
    wr_en = 1'b0; wr_fwd = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    #8;
    // R1: state right after reset
    check("R1", "stall after reset", {31'h0, stall}, 32'h0);
    check("R1", "opa after reset", opa, 32'h0);
    check("R1", "opb after reset", opb, 32'h0);
    @(posedge clk);
    #2;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].s1, VEC[v].s2, VEC[v].we, VEC[v].fwd, VEC[v].wa,
           VEC[v].wd, VEC[v].ps, VEC[v].pa, int'(VEC[v].tag));
    end

    // R1: reset forgets a pending mark set just before it
    step(5'd6, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 1);
    rst_n = 1'b0;
    instr = {5'd6, 5'd0, 22'h0};
    pend_set = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    #2 rst_n = 1'b1;
    model_reset();
    step(5'd6, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 1);
    step(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 1);

    // R6: late write to register 0 is discarded
    step(5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 32'hFFFF_FFFF, 1'b0, 5'd0, 6);
    step(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: got done=0 expected done=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule